// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and every bank owns the same set of word registers at a fixed 0x200-byte stride. Through these registers software drives output values and output enables, reads back synchronized pin levels, selects pad pull resistors, and configures per-pin interrupt detection.

Each pin has three interrupt control bits. One bit chooses level or edge sensing. One bit enables detection on both edges. One bit selects the polarity (rising/high or falling/low). Detected events latch into a raw status register per bank. Software clears those bits by writing ones to a clear register. A mask register gates the raw bits into a masked status. The OR of all masked status bits across all banks drives one registered interrupt line to the host.

The register bus is a plain 32-bit port: byte address, write enable, write data, and read data that is registered one cycle after the address. The bank count is a parameter.

Top module: `banked_gpio`

## Requirements
- R1: After a synchronous reset every register is zero, so `gpio_out`, `gpio_oe`, `pad_pull_up`, `pad_pull_dn`, `irq` and `bus_rdata` are all 0.
- R2: Bank k occupies byte addresses k*0x200 up to k*0x200+0x1FF, and pin p maps to bank p/32, bit p%32. Within a bank, offset 0x04 holds the output values and offset 0x08 holds the output enables (1 = drive). Both read back as written and appear on `gpio_out`/`gpio_oe` one cycle after the write.
- R3: Offset 0x00 returns the pin levels after a two-flop synchronizer. It is read-only, and writes to it are ignored.
- R4: With the level bit (offset 0x0C) at 0, the dual bit (0x10) at 0 and the polarity bit (0x14) at 1, a pin's raw status bit (0x1C) sets on a rising transition only.
- R5: With level 0, dual 0 and polarity 0, the raw status bit sets on a falling transition only.
- R6: With level 0 and dual 1, both transitions set the raw status bit, whatever the polarity bit holds.
- R7: With level 1, the raw bit sets on every cycle the pin is at the polarity level (1 = high, 0 = low). A clear while the level persists leaves the bit set.
- R8: Mask offset 0x18 (1 = enabled) gates raw status into masked status (0x20). `irq` is the OR of all masked bits of all banks, registered one cycle later.
- R9: Writing 1 to a bit of clear offset 0x24 clears that raw bit. Writing 0 has no effect, and the clear offset reads as zero. A set in the same cycle as a clear wins.
- R10: Pull enable is offset 0x38 and pull select is offset 0x34. With enable 0 neither pad pull output is active. With enable 1, select 1 asserts `pad_pull_up` and select 0 asserts `pad_pull_dn`, both registered.
- R11: Reads of unmapped or unaligned offsets return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered one cycle after the address |
| gpio_in | input | NUM_BANKS*32 | Asynchronous pin levels |
| gpio_out | output | NUM_BANKS*32 | Output values |
| gpio_oe | output | NUM_BANKS*32 | Output enables |
| pad_pull_up | output | NUM_BANKS*32 | Pull-up request per pin |
| pad_pull_dn | output | NUM_BANKS*32 | Pull-down request per pin |
| irq | output | 1 | Combined interrupt |

## Verification
A raw status bit held in a wrong state shows up at offset 0x1C on the next read. If the pin is unmasked, it also shows up on `irq` one cycle later. So a missed edge, a spurious set, or a clear that fails or overreaches appears within about four cycles of the pin change or the clear write. Errors in bank decode or field decode appear either on the pad outputs the cycle after a write, or as the wrong bit on readback. Each interrupt mode is driven with both transitions, so detection on the wrong edge shows up as an extra or a missing status bit.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_PINS = 32;
  localparam int OFS_W     = 9;

  localparam logic [OFS_W-1:0] OFS_DIN   = 9'h000;
  localparam logic [OFS_W-1:0] OFS_DOUT  = 9'h004;
  localparam logic [OFS_W-1:0] OFS_OE    = 9'h008;
  localparam logic [OFS_W-1:0] OFS_LVL   = 9'h00C;
  localparam logic [OFS_W-1:0] OFS_DUAL  = 9'h010;
  localparam logic [OFS_W-1:0] OFS_POL   = 9'h014;
  localparam logic [OFS_W-1:0] OFS_MASK  = 9'h018;
  localparam logic [OFS_W-1:0] OFS_RAW   = 9'h01C;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 9'h020;
  localparam logic [OFS_W-1:0] OFS_CLR   = 9'h024;
  localparam logic [OFS_W-1:0] OFS_PSEL  = 9'h034;
  localparam logic [OFS_W-1:0] OFS_PEN   = 9'h038;

  typedef struct packed {
    logic [BANK_PINS-1:0] dout;
    logic [BANK_PINS-1:0] oe;
    logic [BANK_PINS-1:0] lvl;
    logic [BANK_PINS-1:0] dual;
    logic [BANK_PINS-1:0] pol;
    logic [BANK_PINS-1:0] mask;
    logic [BANK_PINS-1:0] psel;
    logic [BANK_PINS-1:0] pen;
  } bank_cfg_t;

  function automatic logic ofs_known(input logic [OFS_W-1:0] o);
    case (o)
      OFS_DIN, OFS_DOUT, OFS_OE, OFS_LVL, OFS_DUAL, OFS_POL, OFS_MASK,
      OFS_RAW, OFS_MSTAT, OFS_CLR, OFS_PSEL, OFS_PEN: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic irq_hit(input logic lvl, input logic dual,
                                   input logic pol, input logic cur,
                                   input logic prv);
    if (lvl)       return pol ? cur : ~cur;
    else if (dual) return cur ^ prv;
    else if (pol)  return cur & ~prv;
    else           return ~cur & prv;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      sync_out <= '0;
    end else begin
      stage1_q <= async_in;
      sync_out <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] level_in,
  input  logic [W-1:0] cfg_lvl,
  input  logic [W-1:0] cfg_dual,
  input  logic [W-1:0] cfg_pol,
  input  logic [W-1:0] cfg_mask,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] masked
);
  import gpio_bank_pkg::*;

  logic [W-1:0] prev_q;
  logic [W-1:0] set_vec;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= level_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb set_vec[i] = irq_hit(cfg_lvl[i], cfg_dual[i], cfg_pol[i],
                                     level_in[i], prev_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= (raw_q & ~clr_vec) | set_vec;
  end

  assign masked = raw_q & cfg_mask;

  // R9
  clr_effect_chk: assert property (@(posedge clk) disable iff (rst)
    ((clr_vec & ~set_vec) != '0) |=> ((raw_q & $past(clr_vec & ~set_vec)) == '0));

  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_vec != '0) |=> ((raw_q & $past(set_vec)) == $past(set_vec)));

  // R4
  raw_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ((raw_q & ~$past(raw_q) & ~$past(set_vec)) == '0));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     ofs,
  input  logic [31:0]          wdata,
  input  logic [BANK_PINS-1:0] pin_in,
  output logic [31:0]          rd_word,
  output logic [BANK_PINS-1:0] pin_out,
  output logic [BANK_PINS-1:0] pin_oe,
  output logic [BANK_PINS-1:0] pull_up,
  output logic [BANK_PINS-1:0] pull_dn,
  output logic [BANK_PINS-1:0] masked
);
  bank_cfg_t            cfg_q;
  logic [BANK_PINS-1:0] pin_sync;
  logic [BANK_PINS-1:0] raw;
  logic [BANK_PINS-1:0] clr_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      case (ofs)
        OFS_DOUT: cfg_q.dout <= wdata;
        OFS_OE:   cfg_q.oe   <= wdata;
        OFS_LVL:  cfg_q.lvl  <= wdata;
        OFS_DUAL: cfg_q.dual <= wdata;
        OFS_POL:  cfg_q.pol  <= wdata;
        OFS_MASK: cfg_q.mask <= wdata;
        OFS_PSEL: cfg_q.psel <= wdata;
        OFS_PEN:  cfg_q.pen  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pull_up <= '0;
      pull_dn <= '0;
    end else begin
      pull_up <= cfg_q.pen & cfg_q.psel;
      pull_dn <= cfg_q.pen & ~cfg_q.psel;
    end
  end

  assign pin_out = cfg_q.dout;
  assign pin_oe  = cfg_q.oe;
  assign clr_vec = (wr_en && ofs == OFS_CLR) ? wdata : '0;

  gpio_sync #(.W(BANK_PINS)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  gpio_irq_detect #(.W(BANK_PINS)) u_det (
    .clk      (clk),
    .rst      (rst),
    .level_in (pin_sync),
    .cfg_lvl  (cfg_q.lvl),
    .cfg_dual (cfg_q.dual),
    .cfg_pol  (cfg_q.pol),
    .cfg_mask (cfg_q.mask),
    .clr_vec  (clr_vec),
    .raw_q    (raw),
    .masked   (masked)
  );

  always_comb begin
    case (ofs)
      OFS_DIN:   rd_word = pin_sync;
      OFS_DOUT:  rd_word = cfg_q.dout;
      OFS_OE:    rd_word = cfg_q.oe;
      OFS_LVL:   rd_word = cfg_q.lvl;
      OFS_DUAL:  rd_word = cfg_q.dual;
      OFS_POL:   rd_word = cfg_q.pol;
      OFS_MASK:  rd_word = cfg_q.mask;
      OFS_RAW:   rd_word = raw;
      OFS_MSTAT: rd_word = masked;
      OFS_PSEL:  rd_word = cfg_q.psel;
      OFS_PEN:   rd_word = cfg_q.pen;
      default:   rd_word = '0;
    endcase
  end

  // R10
  pull_excl_chk: assert property (@(posedge clk) disable iff (rst)
    ((pull_up & pull_dn) == '0));
endmodule

// File: rtl/banked_gpio.sv
module banked_gpio
  import gpio_bank_pkg::*;
#(
  parameter  int NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W    = BANK_W + OFS_W,
  localparam int NPINS     = NUM_BANKS * BANK_PINS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  gpio_in,
  output logic [NPINS-1:0]  gpio_out,
  output logic [NPINS-1:0]  gpio_oe,
  output logic [NPINS-1:0]  pad_pull_up,
  output logic [NPINS-1:0]  pad_pull_dn,
  output logic              irq
);
  logic [BANK_W-1:0] bank_idx;
  logic [OFS_W-1:0]  ofs;
  logic              map_hit;
  logic [31:0]       bank_rd [NUM_BANKS];
  logic [NPINS-1:0]  masked_all;
  logic [31:0]       rd_next;

  assign bank_idx = bus_addr[ADDR_W-1:OFS_W];
  assign ofs      = bus_addr[OFS_W-1:0];
  assign map_hit  = (32'(bank_idx) < NUM_BANKS) && ofs_known(ofs);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = map_hit && (32'(bank_idx) == b);

    gpio_bank u_bank (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (sel && bus_we),
      .ofs     (ofs),
      .wdata   (bus_wdata),
      .pin_in  (gpio_in[b*BANK_PINS +: BANK_PINS]),
      .rd_word (bank_rd[b]),
      .pin_out (gpio_out[b*BANK_PINS +: BANK_PINS]),
      .pin_oe  (gpio_oe[b*BANK_PINS +: BANK_PINS]),
      .pull_up (pad_pull_up[b*BANK_PINS +: BANK_PINS]),
      .pull_dn (pad_pull_dn[b*BANK_PINS +: BANK_PINS]),
      .masked  (masked_all[b*BANK_PINS +: BANK_PINS])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (map_hit && 32'(bank_idx) == b) rd_next = bank_rd[b];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      bus_rdata <= rd_next;
      irq       <= |masked_all;
    end
  end

  // R11
  unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    !map_hit |=> (bus_rdata == '0));

  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(masked_all != '0));
endmodule

// File: tb/banked_gpio_tb.sv
module banked_gpio_tb;
  localparam int NB = 2;
  localparam int AW = 10;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] gpio_in = '0;
  logic [NP-1:0] gpio_out, gpio_oe, pad_pull_up, pad_pull_dn;
  logic          irq;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  banked_gpio #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .pad_pull_up(pad_pull_up),
    .pad_pull_dn(pad_pull_dn), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    wr(10'h024, 32'hFFFF_FFFF);
    wr(10'h224, 32'hFFFF_FFFF);
    settle(2);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 gpio_out", gpio_out, '0);
    chk("R1 gpio_oe", gpio_oe, '0);
    chk("R1 pulls", {pad_pull_up | pad_pull_dn}, '0);
    chk("R1 irq", irq, 0);
    rd(10'h208, d);
    chk("R1 oe readback", d, 0);
  endtask

  task automatic t_output();
    logic [31:0] d;
    wr(10'h204, 32'hA5A5_0001);
    wr(10'h208, 32'h0000_FFFF);
    settle(1);
    chk("R2 bank1 out", gpio_out, {32'hA5A5_0001, 32'h0});
    chk("R2 bank1 oe", gpio_oe, {32'h0000_FFFF, 32'h0});
    rd(10'h204, d);
    chk("R2 readback", d, 32'hA5A5_0001);
    rd(10'h004, d);
    chk("R2 bank0 untouched", d, 0);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    gpio_in[5] = 1'b1;
    gpio_in[40] = 1'b1;
    settle(3);
    rd(10'h000, d);
    chk("R3 bank0 in", d, 32'h20);
    rd(10'h200, d);
    chk("R3 bank1 in", d, 32'h100);
    wr(10'h000, 32'hFFFF_FFFF);
    rd(10'h000, d);
    chk("R3 read-only", d, 32'h20);
  endtask

  task automatic t_rising();
    logic [31:0] d;
    clear_all();
    wr(10'h014, 32'h0000_0008);
    wr(10'h018, 32'h0000_0008);
    @(negedge clk);
    gpio_in[3] = 1'b1;
    settle(6);
    rd(10'h01C, d);
    chk("R4 raw rising", d, 32'h8);
    chk("R8 irq on unmasked", irq, 1);
    rd(10'h020, d);
    chk("R8 masked status", d, 32'h8);
    wr(10'h024, 32'h8);
    settle(2);
    chk("R9 irq drops after clear", irq, 0);
    @(negedge clk);
    gpio_in[3] = 1'b0;
    settle(6);
    rd(10'h01C, d);
    chk("R4 falling ignored", d, 0);
  endtask

  task automatic t_falling();
    logic [31:0] d;
    @(negedge clk);
    gpio_in[4] = 1'b1;
    settle(6);
    rd(10'h01C, d);
    chk("R5 rising ignored", d, 0);
    @(negedge clk);
    gpio_in[4] = 1'b0;
    settle(6);
    rd(10'h01C, d);
    chk("R5 raw falling", d, 32'h10);
    clear_all();
  endtask

  task automatic t_dual();
    logic [31:0] d;
    wr(10'h210, 32'h100);
    wr(10'h214, 32'h100);
    wr(10'h218, 32'h100);
    @(negedge clk);
    gpio_in[40] = 1'b0;
    settle(6);
    rd(10'h21C, d);
    chk("R6 dual falling", d, 32'h100);
    chk("R8 irq from bank1", irq, 1);
    wr(10'h224, 32'h100);
    @(negedge clk);
    gpio_in[40] = 1'b1;
    settle(6);
    rd(10'h21C, d);
    chk("R6 dual rising", d, 32'h100);
    wr(10'h224, 32'h100);
    settle(2);
  endtask

  task automatic t_level();
    logic [31:0] d;
    wr(10'h014, 32'h0000_0048);
    wr(10'h00C, 32'h0000_0040);
    @(negedge clk);
    gpio_in[6] = 1'b1;
    settle(6);
    wr(10'h024, 32'h40);
    rd(10'h01C, d);
    chk("R7 level high reasserts", d, 32'h40);
    @(negedge clk);
    gpio_in[6] = 1'b0;
    settle(4);
    wr(10'h024, 32'h40);
    rd(10'h01C, d);
    chk("R7 level high gone", d, 0);
    wr(10'h00C, 32'h0000_0080);
    settle(2);
    rd(10'h01C, d);
    chk("R7 level low", d, 32'h80);
    wr(10'h00C, 32'h0);
    clear_all();
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(10'h018, 32'h0);
    @(negedge clk);
    gpio_in[3] = 1'b1;
    settle(6);
    rd(10'h01C, d);
    chk("R8 raw while masked", d, 32'h8);
    rd(10'h020, d);
    chk("R8 masked status zero", d, 0);
    chk("R8 irq low when masked", irq, 0);
    wr(10'h024, 32'h0);
    rd(10'h01C, d);
    chk("R9 write zero no effect", d, 32'h8);
    rd(10'h024, d);
    chk("R9 clear reads zero", d, 0);
    clear_all();
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    @(negedge clk);
    gpio_in[3] = 1'b0;
    settle(4);
    clear_all();
    @(negedge clk);
    gpio_in[3] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr = 10'h024; bus_we = 1'b1; bus_wdata = 32'h8;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
    rd(10'h01C, d);
    chk("R9 set wins over clear", d, 32'h8);
    clear_all();
  endtask

  task automatic t_pull();
    wr(10'h038, 32'h0000_000C);
    wr(10'h034, 32'h0000_0204);
    settle(2);
    chk("R10 pull up", pad_pull_up[31:0], 32'h4);
    chk("R10 pull down", pad_pull_dn[31:0], 32'h8);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(10'h028, d);
    chk("R11 hole 0x28", d, 0);
    rd(10'h206, d);
    chk("R11 unaligned", d, 0);
    wr(10'h205, 32'hFFFF_FFFF);
    rd(10'h204, d);
    chk("R11 write ignored", d, 32'hA5A5_0001);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle(2);
    t_reset();
    t_output();
    t_input();
    t_rising();
    t_falling();
    t_dual();
    t_level();
    t_mask();
    t_set_wins();
    t_pull();
    t_unmapped();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule